// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address sequence for four-beat bursts. When a burst begins, it captures a full starting address from the external address bus. After that it generates the later addresses of the burst itself by stepping a 2-bit beat counter. The upper address bits never change inside a burst. Only the two low bits move, and they follow one of two orderings.

A burst can be started by either of two active-low address strobes. One comes from a processor and the other from a cache controller, and they behave the same way. An active-low advance input steps the counter. When advance is not asserted, the current address is held.

A mode input picks the ordering:

- Interleaved ordering: the low bits are the starting low bits XOR the beat count.
- Linear ordering: the low bits are the starting low bits plus the beat count, modulo 4.

All inputs are sampled on the rising clock edge. A change of ordering therefore shows at the address output one cycle after it is applied.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low and after its release, addr_o and beat_o are zero until the first load.
- R2: If ads_proc_ni or ads_cache_ni is low at a rising edge, addr_o equals the sampled addr_i after that edge and beat_o is 0. Either strobe alone is enough.
- R3: With both strobes high and adv_ni low at a rising edge, beat_o increments by one modulo 4. Four advances return addr_o to the starting address.
- R4: With both strobes high and adv_ni high at a rising edge, beat_o and addr_o keep their values, provided the ordering is unchanged.
- R5: With mode_i = 0 (interleaved), addr_o[1:0] equals the starting low bits XOR beat_o.
- R6: With mode_i = 1 (linear), addr_o[1:0] equals the starting low bits plus beat_o, modulo 4.
- R7: addr_o[ADDR_W-1:2] stays at the loaded value for the whole burst.
- R8: mode_i is sampled at the rising edge. A change alters addr_o only after the next rising edge, never between edges.
- R9: A strobe that arrives during a burst reloads from addr_i and resets beat_o to 0. It takes priority over a simultaneous advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External starting address |
| ads_proc_ni | input | 1 | Processor address strobe, active low |
| ads_cache_ni | input | 1 | Cache-controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| mode_i | input | 1 | Ordering select: 0 interleaved, 1 linear |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Current beat index |

## Verification
A corrupted starting-address register shows on addr_o in the cycle right after the load. It appears in the upper bits or in the low bits at beat 0. A counter that skips or sticks shows as a wrong beat_o one edge after the advance or hold, and as a wrong address at the wrap back to the start. A mode register that is bypassed or delayed shows as a low-bit mismatch, either in the interval between the mode change and the next edge or just after that edge. A reload that loses priority leaves beat_o nonzero one cycle after the strobe.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;
  typedef enum logic {ORD_XOR = 1'b0, ORD_WRAP = 1'b1} order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_q <= '0;
    else if (load_i) beat_q <= '0;
    else if (step_i) beat_q <= BEAT_W'(beat_q + 1'b1);
  end

  assign beat_o = beat_q;
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  order_e            order_i,
  output logic [ADDR_W-1:0] base_o,
  output order_e            order_o
);
  logic [ADDR_W-1:0] base_q;
  order_e            order_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      order_q <= ORD_XOR;
    end else begin
      order_q <= order_i;  // ordering always sampled: one-cycle latency
      if (load_i) base_q <= addr_i;
    end
  end

  assign base_o  = base_q;
  assign order_o = order_q;
endmodule

// File: rtl/burst_lo_map.sv
module burst_lo_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] base_lo_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  order_e            order_i,
  output logic [BEAT_W-1:0] lo_o
);
  logic [BEAT_W-1:0] xor_lo;
  logic [BEAT_W-1:0] wrap_lo;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_lo[b] = base_lo_i[b] ^ beat_i[b];
  end

  assign wrap_lo = BEAT_W'(base_lo_i + beat_i);

  always_comb begin
    unique case (order_i)
      ORD_WRAP: lo_o = wrap_lo;
      default:  lo_o = xor_lo;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ads_proc_ni,
  input  logic              ads_cache_ni,
  input  logic              adv_ni,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        beat_o
);
  localparam int LO_W = BEAT_W;

  logic              load;
  logic              step;
  logic [ADDR_W-1:0] base;
  order_e            order_q;
  logic [LO_W-1:0]   beat;
  logic [LO_W-1:0]   lo;

  assign load = !ads_proc_ni || !ads_cache_ni;
  assign step = !load && !adv_ni;  // strobe wins over advance

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (addr_i),
    .order_i(order_e'(mode_i)),
    .base_o (base),
    .order_o(order_q)
  );

  burst_beat_ctr #(.BEAT_W(LO_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .step_i(step),
    .beat_o(beat)
  );

  burst_lo_map #(.BEAT_W(LO_W)) u_map (
    .base_lo_i(base[LO_W-1:0]),
    .beat_i   (beat),
    .order_i  (order_q),
    .lo_o     (lo)
  );

  assign addr_o = {base[ADDR_W-1:LO_W], lo};
  assign beat_o = beat;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ads_proc_ni,
  input logic              ads_cache_ni,
  input logic              adv_ni,
  input logic              mode_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        beat_o
);
  logic armed_q;
  logic strobe;
  assign strobe = !ads_proc_ni || !ads_cache_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) AST_RESET_CLEAR: assert (addr_o == '0 && beat_o == 2'd0); // R1
  end

  AST_LOAD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |=> (addr_o == $past(addr_i) && beat_o == 2'd0)); // R2
  AST_STEP_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe && !adv_ni) |=> beat_o == 2'($past(beat_o) + 2'd1)); // R3
  AST_HOLD_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe && adv_ni) |=> $stable(beat_o)); // R4
  AST_XOR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !strobe && !mode_i && !$past(mode_i))
      |=> (addr_o[1:0] ^ beat_o) == $past(addr_o[1:0] ^ beat_o)); // R5
  AST_WRAP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !strobe && mode_i && $past(mode_i))
      |=> 2'(addr_o[1:0] - beat_o) == $past(2'(addr_o[1:0] - beat_o))); // R6
  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe |=> $stable(addr_o[ADDR_W-1:2])); // R7
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .ads_proc_ni(ads_proc_ni),
  .ads_cache_ni(ads_cache_ni), .adv_ni(adv_ni), .mode_i(mode_i),
  .addr_o(addr_o), .beat_o(beat_o)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ads_p = 1'b1, ads_c = 1'b1, adv = 1'b1, mode = 1'b0;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ads_proc_ni(ads_p),
    .ads_cache_ni(ads_c), .adv_ni(adv), .mode_i(mode),
    .addr_o(addr_o), .beat_o(beat_o)
  );

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] s, logic [1:0] b, logic m);
    return {s[AW-1:2], m ? 2'(s[1:0] + b) : (s[1:0] ^ b)};
  endfunction

  task automatic chk(string req, logic [AW-1:0] ea, logic [1:0] eb);
    checks++;
    if (addr_o !== ea || beat_o !== eb) begin
      failures++;
      $display("FAIL %s addr=%h beat=%0d expected addr=%h beat=%0d", req, addr_o, beat_o, ea, eb);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load(logic [AW-1:0] a, bit use_cache, logic m);
    addr = a; mode = m; adv = 1'b1;
    if (use_cache) ads_c = 1'b0; else ads_p = 1'b0;
    tick();
    ads_p = 1'b1; ads_c = 1'b1; addr = ~a;
  endtask

  task automatic t_reset();
    chk("R1", '0, 2'd0);
    rst_n = 1'b1; tick(); tick();
    chk("R1", '0, 2'd0);
  endtask

  task automatic t_burst(logic [AW-1:0] s, logic m, bit use_cache);
    load(s, use_cache, m);
    chk("R2", s, 2'd0);
    adv = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      tick();
      chk(m ? "R6" : "R5", exp_addr(s, 2'(i), m), 2'(i));
      if (addr_o[AW-1:2] !== s[AW-1:2]) begin
        checks++; failures++;
        $display("FAIL R7 upper=%h expected %h", addr_o[AW-1:2], s[AW-1:2]);
      end
    end
    chk("R3", s, 2'd0);
    adv = 1'b1;
  endtask

  task automatic t_hold();
    logic [AW-1:0] s = 19'h2ABC5;
    load(s, 0, 0);
    adv = 1'b0; tick(); adv = 1'b1;
    tick(); tick();
    chk("R4", exp_addr(s, 2'd1, 0), 2'd1);
  endtask

  task automatic t_reload();
    logic [AW-1:0] s = 19'h11112;
    logic [AW-1:0] n = 19'h4F00B;
    load(s, 0, 1);
    adv = 1'b0; tick(); tick();
    chk("R3", exp_addr(s, 2'd2, 1), 2'd2);
    addr = n; ads_c = 1'b0; tick();  // strobe with advance still low
    ads_c = 1'b1;
    chk("R9", n, 2'd0);
    tick();
    chk("R9", exp_addr(n, 2'd1, 1), 2'd1);
    adv = 1'b1;
  endtask

  task automatic t_mode();
    logic [AW-1:0] s = 19'h30001;
    load(s, 1, 0);
    adv = 1'b0; tick(); adv = 1'b1;
    chk("R5", exp_addr(s, 2'd1, 0), 2'd1);
    mode = 1'b1; #2;
    chk("R8", exp_addr(s, 2'd1, 0), 2'd1);
    tick();
    chk("R8", exp_addr(s, 2'd1, 1), 2'd1);
    mode = 1'b0; #2;
    chk("R8", exp_addr(s, 2'd1, 1), 2'd1);
    tick();
    chk("R8", exp_addr(s, 2'd1, 0), 2'd1);
  endtask

  initial begin
    #2;
    t_reset();
    t_burst(19'h12345, 0, 0);
    t_burst(19'h0ABC2, 1, 1);
    t_burst(19'h7FFF3, 0, 1);
    t_burst(19'h00003, 1, 0);
    t_hold();
    t_reload();
    t_mode();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule